// File: doc/BRIEF.md
# Link Activity Sync Detector

This block decides whether a video link is carrying live traffic by watching the recovered data-enable line. Data enable toggles at every line boundary while a source is active. The block therefore counts transitions of that line, and it raises a link-alive flag once enough of them have been seen. When data enable stops moving, an inactivity timer runs. After a long quiet period, given in clock cycles, the flag drops and the transition count starts again from zero.

Raising and lowering the flag use different rules. The flag rises quickly, after a few dozen transitions. It falls slowly, only after a timeout that can be many milliseconds long, so a short blanking gap never knocks a live link down. The flag is a plain registered output that is always driven. It is meant to be wired to the output power-down input of the pixel formatter, so the panel outputs switch off when no activity is seen.

The data-enable input is asynchronous to the block clock and passes through a two-flop synchronizer before edge detection.

Top module: `link_sync_detect`

## Requirements
- R1: During and after a synchronous active-high reset, `link_alive` is 0 and both internal counts are zero.
- R2: Rising and falling transitions of `de_in` each count as one edge, so EDGE_THRESH/2 full pulses are exactly enough to raise the flag, and fewer are not.
- R3: `link_alive` rises once EDGE_THRESH edges have been seen since the last reset or timeout. EDGE_THRESH-1 edges leave it low for as long as no timeout occurs.
- R4: Every edge restarts the inactivity timer. While edges keep arriving with fewer than IDLE_TIMEOUT edge-free cycles between them, `link_alive` stays 1.
- R5: After IDLE_TIMEOUT consecutive clock cycles with no detected edge, `link_alive` goes to 0 and the edge count is cleared, so a fresh EDGE_THRESH edges are needed to raise it again.
- R6: Only transitions matter. `de_in` held constant at 1 is treated as inactivity in the same way as a constant 0.
- R7: `de_in` goes through a two-flop synchronizer. When the change that completes the threshold lands before rising clock edge 1, `link_alive` is 1 after rising clock edge 3 and still 0 after edge 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| de_in | input | 1 | Recovered data enable, asynchronous |
| link_alive | output | 1 | Link-alive flag, always driven |

## Verification
The bench drives four kinds of data-enable pattern. Slow toggles stop just short of the threshold and then complete it, which separates an off-by-one in the count and pins down the synchronizer latency. One-cycle pulses check that both transition directions are counted. Sparse toggles with gaps just under the timeout tell an inactivity timer that restarts on each edge from one that only counts total time. Long constant-high and constant-low holds confirm the flag falls on inactivity at either level. A follow-up burst below the threshold then proves the count was cleared. A behavioural model built from a sample queue and integer counters is compared with the flag on every clock.

// File: rtl/lsd_pkg.sv
package lsd_pkg;

    typedef enum logic {
        LINK_DOWN = 1'b0,
        LINK_UP   = 1'b1
    } link_state_e;

    // events passed from the front end and timer to the flag logic
    typedef struct packed {
        logic edge_seen;
        logic expire;
    } lsd_evt_t;

    function automatic int unsigned cnt_width(input int unsigned limit);
        return (limit < 2) ? 1 : $clog2(limit + 1);
    endfunction

endpackage

// File: rtl/lsd_sync_edge.sv
module lsd_sync_edge #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic edge_seen
);
    logic [STAGES-1:0] chain;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain  <= '0;
            prev_q <= 1'b0;
        end else begin
            chain  <= {chain[STAGES-2:0], async_in};
            prev_q <= chain[STAGES-1];
        end
    end

    assign edge_seen = chain[STAGES-1] ^ prev_q;

    // an edge can only appear when the synchronized level moved one cycle earlier
    AST_EDGE_FROM_SYNC: assert property (@(posedge clk) disable iff (rst)
        edge_seen |-> (chain[STAGES-1] != $past(chain[STAGES-1]))); // R7
endmodule

// File: rtl/lsd_edge_count.sv
module lsd_edge_count
    import lsd_pkg::*;
#(
    parameter int unsigned THRESH = 24
) (
    input  logic clk,
    input  logic rst,
    input  lsd_evt_t evt,
    output logic reached
);
    localparam int unsigned W = cnt_width(THRESH);
    localparam logic [W-1:0] LAST = W'(THRESH - 1);
    localparam logic [W-1:0] FULL = W'(THRESH);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (evt.expire) begin
            cnt_q <= '0;
        end else if (evt.edge_seen && (cnt_q != FULL)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // the edge now seen completes the threshold
    assign reached = evt.edge_seen && (cnt_q >= LAST);

    AST_CNT_CLEARED: assert property (@(posedge clk) disable iff (rst)
        evt.expire |=> (cnt_q == '0)); // R5
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= FULL); // R3
endmodule

// File: rtl/lsd_idle_timer.sv
module lsd_idle_timer
    import lsd_pkg::*;
#(
    parameter int unsigned TIMEOUT = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic edge_seen,
    output logic expire
);
    localparam int unsigned W = cnt_width(TIMEOUT);
    localparam logic [W-1:0] LAST = W'(TIMEOUT - 1);
    localparam logic [W-1:0] FULL = W'(TIMEOUT);

    logic [W-1:0] quiet_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            quiet_q <= '0;
        end else if (edge_seen) begin
            quiet_q <= '0;
        end else if (quiet_q != FULL) begin
            quiet_q <= quiet_q + 1'b1;
        end
    end

    // fires once, on the TIMEOUT-th edge-free cycle
    assign expire = !edge_seen && (quiet_q == LAST);

    AST_TIMER_RESTART: assert property (@(posedge clk) disable iff (rst)
        edge_seen |=> (quiet_q == '0)); // R4
    AST_EXPIRE_ONCE: assert property (@(posedge clk) disable iff (rst)
        expire |=> !expire); // R5
endmodule

// File: rtl/link_sync_detect.sv
module link_sync_detect
    import lsd_pkg::*;
#(
    parameter int unsigned EDGE_THRESH  = 24,
    parameter int unsigned IDLE_TIMEOUT = 20_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic de_in,
    output logic link_alive
);
    lsd_evt_t    evt;
    logic        reached;
    link_state_e state_q;

    lsd_sync_edge #(.STAGES(2)) u_front (
        .clk      (clk),
        .rst      (rst),
        .async_in (de_in),
        .edge_seen(evt.edge_seen)
    );

    lsd_idle_timer #(.TIMEOUT(IDLE_TIMEOUT)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .edge_seen(evt.edge_seen),
        .expire   (evt.expire)
    );

    lsd_edge_count #(.THRESH(EDGE_THRESH)) u_count (
        .clk    (clk),
        .rst    (rst),
        .evt    (evt),
        .reached(reached)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= LINK_DOWN;
        end else if (evt.expire) begin
            state_q <= LINK_DOWN;
        end else if (reached) begin
            state_q <= LINK_UP;
        end
    end

    assign link_alive = (state_q == LINK_UP);

    AST_RISE_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
        $rose(link_alive) |-> $past(evt.edge_seen)); // R3
    AST_FALL_ON_EXPIRE: assert property (@(posedge clk) disable iff (rst)
        $fell(link_alive) |-> $past(evt.expire)); // R5
    AST_ALIVE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (link_alive && !evt.expire) |=> link_alive); // R4
    AST_RESET_LOW: assert property (@(posedge clk)
        $past(rst) |-> !link_alive); // R1
endmodule

// File: tb/link_sync_detect_tb_top.sv
module link_sync_detect_tb_top;
    localparam int TH = 24;
    localparam int TO = 200;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic de  = 1'b0;
    logic link_alive;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    link_sync_detect #(.EDGE_THRESH(TH), .IDLE_TIMEOUT(TO)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .de_in     (de),
        .link_alive(link_alive)
    );

    // behavioural reference: queue of de samples, integer counters
    bit samp[$];
    int edges_m;
    int quiet_m;
    bit alive_m;

    always @(posedge clk) begin
        if (rst) begin
            samp = '{1'b0, 1'b0, 1'b0};
            edges_m = 0;
            quiet_m = 0;
            alive_m = 0;
        end else begin
            if (samp[1] != samp[0]) begin
                edges_m++;
                quiet_m = 0;
                if (edges_m >= TH) alive_m = 1;
            end else begin
                quiet_m++;
                if (quiet_m == TO) begin
                    edges_m = 0;
                    alive_m = 0;
                end
            end
            samp.push_back(de);
            void'(samp.pop_front());
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            checks++;
            if (link_alive !== alive_m) begin
                errors++;
                $display("FAIL R3/R4/R5 model cycle: actual %0b expected %0b at %0t",
                         link_alive, alive_m, $time);
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic toggles(input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            de = ~de;
            step(gap);
        end
    endtask

    task automatic expect_alive(input bit exp, input string req);
        checks++;
        if (link_alive !== exp) begin
            errors++;
            $display("FAIL %s: actual %0b expected %0b at %0t", req, link_alive, exp, $time);
        end
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        step(1);
        expect_alive(1'b0, "R1 during reset");
        step(3);
        rst = 1'b0;
        step(1);
        expect_alive(1'b0, "R1 after reset");

        // R3: one edge short of the threshold
        toggles(TH - 1, 3);
        step(20);
        expect_alive(1'b0, "R3 below threshold");

        // R7: completing edge, latency of three clock edges
        @(negedge clk);
        de = ~de;
        @(negedge clk);
        expect_alive(1'b0, "R7 edge 1");
        @(negedge clk);
        expect_alive(1'b0, "R7 edge 2");
        @(negedge clk);
        expect_alive(1'b1, "R7 edge 3");

        // R4: sparse toggles, gaps just under the timeout
        toggles(4, TO - 20);
        expect_alive(1'b1, "R4 sparse toggles");
        toggles(3, TO - 1);
        expect_alive(1'b1, "R4 boundary gap");

        // R6: hold high until timeout
        if (de == 1'b0) toggles(1, 0);
        step(TO + 10);
        expect_alive(1'b0, "R6 constant high");

        // R5: count was cleared by the timeout
        toggles(TH - 1, 1);
        step(4);
        expect_alive(1'b0, "R5 count cleared");
        step(TO + 10);
        expect_alive(1'b0, "R5 timeout low");

        // R2: single-cycle pulses, both directions count
        toggles(TH / 2, 0);
        step(5);
        expect_alive(1'b0, "R2 half pulses");
        toggles(TH / 2, 0);
        step(4);
        expect_alive(1'b1, "R2 full pulses");

        // R5: constant low timeout, then re-arm
        if (de == 1'b1) toggles(1, 0);
        step(TO + 10);
        expect_alive(1'b0, "R5 constant low");
        toggles(TH, 2);
        step(4);
        expect_alive(1'b1, "R5 re-arm");

        // R1: reset mid-activity
        @(negedge clk);
        rst = 1'b1;
        step(2);
        expect_alive(1'b0, "R1 reset while alive");
        rst = 1'b0;
        step(3);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule